// File: doc/BRIEF.md
# Cascaded Shift-Damped Smoothing Interpolator

This block turns a word that changes only now and then into a smooth stream of values at a much faster update rate. A load strobe copies a new sample into a holding register. On every clock-enable tick, each filter stage moves its accumulator toward its target by the remaining distance divided by 2^K. The divide is an arithmetic right shift, so no multiplier is needed. Ticks are not tied to loads, so one held sample is smoothed over as many ticks as the fast rate allows.

One stage gives a first-order exponential approach. With `STAGES = 2`, a second stage follows the first stage's accumulator and the response becomes second order. Each accumulator keeps K fractional bits below the sample's integer part. Each step is rounded away from zero, so a stage always lands exactly on a constant target. The output is the top `OUT_W` bits of the last stage's integer part.

Top module: `smooth_interp`

## Requirements
- R1: While `rst_n` is low, the holding register and every stage accumulator are cleared, so `out_data` reads 0 after reset.
- R2: A cycle with `load` high copies `load_data` into the holding register. A tick in the same cycle still uses the value held before that load.
- R3: A cycle without `tick` leaves every accumulator, and therefore `out_data`, unchanged, whether or not `load` is high.
- R4: On a tick, each stage adds (target − accumulator) / 2^K to its accumulator, rounded away from zero. The target of stage 0 is the held sample shifted left by K bits.
- R5: A stage update never passes its target and never moves away from it, and the accumulator never overflows.
- R6: With the input held constant, every stage settles exactly on the held value, so `out_data` equals the top `OUT_W` bits of the held sample.
- R7: With `STAGES = 2`, the second stage's target on a tick is the first stage's accumulator as it was before that tick.
- R8: `out_data` is bits [AW−1 : AW−OUT_W] of the last accumulator, where AW = IN_W + K. The values are two's complement.
- R9: The block works for K = 4 and K = 5, in a 16-bit and in an 8-bit datapath, with one stage or two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe that captures a new sample |
| load_data | input | IN_W | New sample, two's complement |
| tick | input | 1 | Update enable for all stages |
| out_data | output | OUT_W | Truncated smoothed value, two's complement |

## Verification
The assertions assume that `load`, `tick` and `load_data` are known values on every clock edge after reset. They also assume `OUT_W` is no wider than `IN_W`. Under those conditions the no-overshoot and no-overflow properties hold for any input, including full-scale jumps between the most negative and the most positive sample.

The bench drives inputs only on the falling edge and always gives them defined values. It covers the full-scale jumps, loads that land in the same cycle as a tick, and long runs with no tick at all.

// File: rtl/smooth_interp.sv
module smooth_interp #(
  parameter int IN_W   = 16,
  parameter int OUT_W  = 8,
  parameter int K      = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IN_W-1:0]  load_data,
  input  logic             tick,
  output logic [OUT_W-1:0] out_data
);
  localparam int AW  = IN_W + K;
  localparam int DW  = AW + 2;
  localparam int RND = (1 << K) - 1;

  logic signed [IN_W-1:0] hold;
  logic signed [AW-1:0]   acc  [STAGES];
  logic signed [AW-1:0]   tgt  [STAGES];
  logic signed [DW-1:0]   diff [STAGES];
  logic signed [DW-1:0]   step [STAGES];
  logic signed [DW-1:0]   nxt  [STAGES];

  always_ff @(posedge clk)
    if (!rst_n)    hold <= '0;
    else if (load) hold <= load_data;

  assign tgt[0] = {hold, {K{1'b0}}};

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_chain
      assign tgt[g] = acc[g-1];
    end
    for (g = 0; g < STAGES; g++) begin : g_stage
      assign diff[g] = DW'(tgt[g]) - DW'(acc[g]);
      assign step[g] = diff[g][DW-1] ? (diff[g] >>> K)
                                     : ((diff[g] + DW'(RND)) >>> K);
      assign nxt[g]  = DW'(acc[g]) + step[g];

      always_ff @(posedge clk)
        if (!rst_n)    acc[g] <= '0;
        else if (tick) acc[g] <= nxt[g][AW-1:0];

      assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (nxt[g][DW-1:AW-1] == '0 || nxt[g][DW-1:AW-1] == '1));
      assert_rise_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (tgt[g] >= acc[g]) |=> (acc[g] >= $past(acc[g])) && (acc[g] <= $past(tgt[g])));
      assert_fall_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (tgt[g] <= acc[g]) |=> (acc[g] <= $past(acc[g])) && (acc[g] >= $past(tgt[g])));
      assert_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (tgt[g] != acc[g]) |=> acc[g] != $past(acc[g]));
      assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(acc[g]));
    end
  endgenerate

  assign out_data = acc[STAGES-1][AW-1 -: OUT_W];

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold == $past(load_data));
  assert_out_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_data));
endmodule

// File: tb/sim_smooth_interp.sv
module sim_smooth_interp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [15:0] ld16 = '0;
  logic tick = 1'b0;
  logic [7:0] out0, out1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  smooth_interp u0 (.clk(clk), .rst_n(rst_n), .load(load), .load_data(ld16),
                    .tick(tick), .out_data(out0));
  smooth_interp #(.IN_W(8), .OUT_W(8), .K(5), .STAGES(1)) u1 (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(ld16[7:0]),
    .tick(tick), .out_data(out1));

  longint a0 [2];
  longint a1, h0, h1;
  int q0[$], q1[$];
  string qt[$];
  string tag = "R1";

  function automatic longint fdiv(longint v, int n);
    longint p = longint'(1) << n;
    if (v >= 0) return v / p;
    return -((-v + p - 1) / p);
  endfunction

  function automatic longint adv(longint a, longint t, int k);
    longint d = t - a;
    longint p = longint'(1) << k;
    if (d > 0) return a + (d + p - 1) / p;
    if (d < 0) return a - ((-d + p - 1) / p);
    return a;
  endfunction

  function automatic longint sx(longint v, int w);
    longint m = longint'(1) << w;
    v = v & (m - 1);
    return (v >= m / 2) ? v - m : v;
  endfunction

  task automatic cyc(input bit ld, input logic [15:0] d, input bit tk);
    @(negedge clk);
    load = ld; ld16 = d; tick = tk;
    if (tk) begin
      a0[1] = adv(a0[1], a0[0], 4);
      a0[0] = adv(a0[0], h0 * 16, 4);
      a1    = adv(a1, h1 * 32, 5);
    end
    if (ld) begin
      h0 = sx(d, 16);
      h1 = sx(d[7:0], 8);
    end
    q0.push_back(int'(fdiv(a0[1], 12) & 8'hFF));
    q1.push_back(int'(fdiv(a1, 5) & 8'hFF));
    qt.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q0.size() > 0) begin
      int e0, e1;
      string t;
      e0 = q0.pop_front(); e1 = q1.pop_front(); t = qt.pop_front();
      checks += 2;
      if (int'(out0) != e0) begin
        errors++;
        $display("FAIL %s R7 R8 u0 got %0h exp %0h", t, out0, e0);
      end
      if (int'(out1) != e1) begin
        errors++;
        $display("FAIL %s R9 u1 got %0h exp %0h", t, out1, e1);
      end
    end
  end

  task automatic direct(input string t, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", t, got, exp);
    end
  endtask

  task automatic settle_check(input logic [15:0] d);
    tag = "R6";
    for (int i = 0; i < 600; i++) cyc(1'b0, 16'h0, 1'b1);
    cyc(1'b0, 16'h0, 1'b0);
    @(negedge clk);
    direct("R6 u0 settle", int'(out0), int'(d[15:8]));
    direct("R6 R9 u1 settle", int'(out1), int'(d[7:0]));
  endtask

  initial begin
    a0[0] = 0; a0[1] = 0; a1 = 0; h0 = 0; h1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    cyc(1'b0, 16'h0, 1'b0);
    cyc(1'b0, 16'h0, 1'b0);
    tag = "R3";
    cyc(1'b1, 16'h40A5, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 16'h1234, 1'b0);
    tag = "R4";
    for (int i = 0; i < 60; i++) cyc(1'b0, 16'h0, 1'b1);
    settle_check(16'h40A5);
    tag = "R5";
    cyc(1'b1, 16'h8000, 1'b1);
    for (int i = 0; i < 80; i++) cyc(1'b0, 16'h0, i[0]);
    cyc(1'b1, 16'h7FFF, 1'b0);
    for (int i = 0; i < 80; i++) cyc(1'b0, 16'h0, 1'b1);
    settle_check(16'h7FFF);
    tag = "R2";
    cyc(1'b1, 16'hC03C, 1'b1);
    cyc(1'b1, 16'h0155, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b0, 16'h0, 1'b1);
    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      cyc(r[3:0] == 4'd0, r[31:16], r[4] | r[5]);
    end
    cyc(1'b1, 16'hC03C, 1'b0);
    settle_check(16'hC03C);
    tag = "R1";
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; load = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    a0[0] = 0; a0[1] = 0; a1 = 0; h0 = 0; h1 = 0;
    cyc(1'b0, 16'h0, 1'b1);
    cyc(1'b0, 16'h0, 1'b1);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule